// File: doc/BRIEF.md
# Bus Master Memory Protection Checker

This block guards one external bus master. Software programs a small bank of protection regions through a simple register port. Each region is a 64-bit configuration word holding a packed region address, access permissions, a matching mode and a sticky lock. Every transaction the master presents on the check port is compared against all enabled regions at once. A registered allow or deny comes back on the next clock.

The lowest-numbered region that covers the address decides the outcome. Regions are naturally aligned powers of two, at least 8 bytes. The region's size is encoded by the trailing ones of its address field, and that field holds the byte address shifted right by two. An address that no enabled region covers is denied.

The first denial after reset or after a clear is latched in a fail record. The record holds the word address, the direction and the master ID. It is not changed by later denials, and only a pulse on a dedicated clear input removes it.

Top module: `mpc_checker`

## Requirements
- R1: A configuration word keeps bits [37:0] (address field), bits [58:56] (permissions), bits [60:59] (matching mode) and bit 63 (lock). Every other bit is stored as zero and reads back as zero.
- R2: A register write or read with `cfg_idx` at or above `NUM_REGIONS` raises `cfg_err` one cycle later and changes no region. Such a read returns zero. In-range accesses return `cfg_err` low.
- R3: Once bit 63 of a region is set, writes to that region are ignored until reset, so its lock can never be cleared by software.
- R4: A region in mode 3 whose address field ends in k ones covers the 2^(k+3) bytes whose byte address, shifted right by 2, equals the field with its low k+1 bits ignored. An all-ones field covers every address.
- R5: A region whose matching mode is 0, 1 or 2 never matches.
- R6: When several regions match, the lowest-numbered one alone decides. When none matches, the access is denied.
- R7: `req_type` 0 (read) is allowed by permission bit 56, 1 (write) by bit 57, and 2 (execute) by bit 58. Type 3 is always denied.
- R8: `rsp_valid` is high exactly in the cycle after `req_valid` was high, and `rsp_allow` is high only together with it.
- R9: When the record is empty, a denial captures `fail_status` in the same cycle as its response. The record is laid out as: bits [37:0] = `req_addr[39:2]`, bit 38 = 1 for a write and 0 otherwise, bits [42:39] = `req_id`, bit 43 = failed flag, and the upper bits zero.
- R10: While the failed flag is set, later denials leave `fail_status` unchanged.
- R11: A `fail_clear` pulse zeroes `fail_status` on the next cycle. It takes precedence over a denial in the same cycle, which is then not recorded.
- R12: After reset, all regions are zero, `fail_status` is zero and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_idx | input | IDX_W | Region index |
| cfg_wdata | input | 64 | Configuration word to write |
| cfg_rdata | output | 64 | Registered read data |
| cfg_err | output | 1 | Index out of range, one cycle after the access |
| req_valid | input | 1 | Check request strobe |
| req_addr | input | 40 | Byte address of the access |
| req_type | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| req_id | input | 4 | Master ID for the fail record |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_allow | output | 1 | Access permitted |
| fail_clear | input | 1 | Clears the fail record |
| fail_status | output | 64 | Latched fail record |

## Verification
A wrong region register shows up at the next readback. It also shows up as a flipped allow/deny one cycle after any access that lands in that region. An overlap test shows it too, because priority hides some errors until a lower region is removed or left unmatched. A corrupted fail record becomes visible on `fail_status` in the same cycle as the denial that wrote it. It stays there until the clear, so the sticky-first-fault rule is checked by issuing several denials before that clear. Boundary addresses just inside and just outside each power-of-two window expose an off-by-one in the trailing-ones mask on the very next response.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int WORD_W   = 64;
  localparam int FIELD_W  = 38;
  localparam int ID_W     = 4;
  localparam int LOCK_BIT = 63;
  localparam int AM_HI    = 60;
  localparam int AM_LO    = 59;
  localparam int PERM_LO  = 56;
  localparam int RW_BIT   = 38;
  localparam int ID_LO    = 39;
  localparam int FAIL_BIT = 43;

  localparam logic [1:0] AM_NAPOT = 2'd3;

  // bits a configuration write may set
  localparam logic [WORD_W-1:0] KEEP_MASK = 64'h9F00_003F_FFFF_FFFF;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;
endpackage

// File: rtl/mpc_region_file.sv
module mpc_region_file
  import mpc_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic                                rd_en,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [WORD_W-1:0]                   wdata,
  output logic [WORD_W-1:0]                   rdata,
  output logic                                err,
  output logic [NUM_REGIONS-1:0][WORD_W-1:0]  regions
);
  logic              in_range;
  logic [WORD_W-1:0] rd_mux;

  assign in_range = (32'(idx) < NUM_REGIONS);

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (32'(idx) == i) rd_mux = regions[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regions <= '0;
      rdata   <= '0;
      err     <= 1'b0;
    end else begin
      err <= (wr_en || rd_en) && !in_range;
      if (rd_en) rdata <= rd_mux;
      for (int i = 0; i < NUM_REGIONS; i++)
        if (wr_en && 32'(idx) == i && !regions[i][LOCK_BIT])
          regions[i] <= wdata & KEEP_MASK;
    end
  end

  // R2: out-of-range access answered with an error
  a_r2_range_err: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_range) |=> err);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lock_chk
    // R3: a locked word never changes
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (rst)
      regions[g][LOCK_BIT] |=> $stable(regions[g]));
  end
endmodule

// File: rtl/mpc_napot_match.sv
module mpc_napot_match
  import mpc_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic [NUM_REGIONS-1:0][WORD_W-1:0] regions,
  input  logic [FIELD_W-1:0]                 word_addr,
  output logic                               hit_any,
  output logic [2:0]                         perm,
  output logic [NUM_REGIONS-1:0]             winner
);
  logic [NUM_REGIONS-1:0] hit;
  logic                   unused_bits;

  assign unused_bits = ^regions;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    logic [FIELD_W-1:0] fld;
    logic [FIELD_W-1:0] ign;
    assign fld    = regions[g][FIELD_W-1:0];
    // trailing ones plus the next bit are don't-care positions
    assign ign    = fld ^ (fld + FIELD_W'(1));
    assign hit[g] = (regions[g][AM_HI:AM_LO] == AM_NAPOT) &&
                    ((word_addr & ~ign) == (fld & ~ign));
  end

  always_comb begin
    winner = '0;
    perm   = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--)
      if (hit[i]) begin
        winner    = '0;
        winner[i] = 1'b1;
        perm      = regions[i][PERM_LO+2:PERM_LO];
      end
  end

  assign hit_any = |hit;
endmodule

// File: rtl/mpc_fail_record.sv
module mpc_fail_record
  import mpc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               capture,
  input  logic               clear,
  input  logic [FIELD_W-1:0] addr,
  input  logic               rw,
  input  logic [ID_W-1:0]    id,
  output logic [WORD_W-1:0]  status
);
  localparam int PAD_W = WORD_W - FAIL_BIT - 1;

  always_ff @(posedge clk) begin
    if (rst || clear)
      status <= '0;
    else if (capture && !status[FAIL_BIT])
      status <= {{PAD_W{1'b0}}, 1'b1, id, rw, addr};
  end

  // R10: a held record is not overwritten
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (status[FAIL_BIT] && !clear) |=> $stable(status));
  // R11: clear empties the record
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (status == '0));
  // R9: first denial sets the flag
  a_r9_capture: assert property (@(posedge clk) disable iff (rst)
    (capture && !status[FAIL_BIT] && !clear) |=> status[FAIL_BIT]);
endmodule

// File: rtl/mpc_checker.sv
module mpc_checker
  import mpc_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_wr,
  input  logic                  cfg_rd,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [WORD_W-1:0]     cfg_wdata,
  output logic [WORD_W-1:0]     cfg_rdata,
  output logic                  cfg_err,
  input  logic                  req_valid,
  input  logic [FIELD_W+1:0]    req_addr,
  input  logic [1:0]            req_type,
  input  logic [ID_W-1:0]       req_id,
  output logic                  rsp_valid,
  output logic                  rsp_allow,
  input  logic                  fail_clear,
  output logic [WORD_W-1:0]     fail_status
);
  logic [NUM_REGIONS-1:0][WORD_W-1:0] regions;
  logic [NUM_REGIONS-1:0]             winner;
  logic [2:0]                         perm;
  logic                               hit_any;
  logic                               perm_ok;
  logic                               allow_c;
  logic                               unused_low;
  acc_e                               acc;

  assign unused_low = ^req_addr[1:0];
  assign acc        = acc_e'(req_type);

  mpc_region_file #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .rd_en(cfg_rd), .idx(cfg_idx),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .err(cfg_err), .regions(regions)
  );

  mpc_napot_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
    .regions(regions), .word_addr(req_addr[FIELD_W+1:2]),
    .hit_any(hit_any), .perm(perm), .winner(winner)
  );

  always_comb begin
    unique case (acc)
      ACC_READ:  perm_ok = perm[0];
      ACC_WRITE: perm_ok = perm[1];
      ACC_EXEC:  perm_ok = perm[2];
      default:   perm_ok = 1'b0;
    endcase
  end

  assign allow_c = hit_any && perm_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid && allow_c;
    end
  end

  mpc_fail_record u_fail (
    .clk(clk), .rst(rst), .capture(req_valid && !allow_c), .clear(fail_clear),
    .addr(req_addr[FIELD_W+1:2]), .rw(acc == ACC_WRITE), .id(req_id),
    .status(fail_status)
  );

  // R8: response follows request by one cycle
  a_r8_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r8_allow_qual: assert property (@(posedge clk) disable iff (rst)
    rsp_allow |-> rsp_valid);
  // R6: one winner at most; no match means deny
  a_r6_one_winner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(winner));
  a_r6_nomatch_deny: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit_any) |=> !rsp_allow);
  // R7: reserved type never allowed
  a_r7_rsvd_deny: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_type == 2'd3) |=> !rsp_allow);
endmodule

// File: tb/test_mpc_checker.sv
module test_mpc_checker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        cfg_err;
  logic        req_valid = 1'b0;
  logic [39:0] req_addr = '0;
  logic [1:0]  req_type = '0;
  logic [3:0]  req_id = '0;
  logic        rsp_valid, rsp_allow;
  logic        fail_clear = 1'b0;
  logic [63:0] fail_status;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  mpc_checker #(.NUM_REGIONS(8), .IDX_W(4)) i_mpc_checker (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_addr(req_addr), .req_type(req_type),
    .req_id(req_id), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .fail_clear(fail_clear), .fail_status(fail_status)
  );

  function automatic logic [37:0] fld(input logic [39:0] base, input logic [39:0] size);
    logic [39:0] t;
    t = (base >> 2) | ((size >> 3) - 40'd1);
    return t[37:0];
  endfunction

  function automatic logic [63:0] mk(input logic [37:0] f, input logic [2:0] p,
                                     input logic [1:0] am, input logic lk);
    return {lk, 2'b00, am, p, 18'b0, f};
  endfunction

  function automatic logic [63:0] st(input logic [39:0] a, input logic rw, input logic [3:0] id);
    return {20'b0, 1'b1, id, rw, a[39:2]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [3:0] idx, input logic [63:0] d, input logic exp_err, input string tag);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(tag, 64'(cfg_err), 64'(exp_err));
  endtask

  task automatic rd_cfg(input logic [3:0] idx, input logic [63:0] exp_d, input logic exp_err, input string tag);
    cfg_rd = 1'b1; cfg_idx = idx;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(tag, {cfg_err, cfg_rdata[62:0]}, {exp_err, exp_d[62:0]});
    chk(tag, 64'(cfg_rdata[63]), 64'(exp_d[63]));
  endtask

  task automatic acc(input logic [39:0] a, input logic [1:0] t, input logic [3:0] id,
                     input logic exp_allow, input string tag);
    req_valid = 1'b1; req_addr = a; req_type = t; req_id = id;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {62'b0, rsp_valid, rsp_allow}, {62'b0, 1'b1, exp_allow});
  endtask

  task automatic t_reset;
    chk("R12 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R12 fail_status after reset", fail_status, 64'd0);
    rd_cfg(4'd0, 64'd0, 1'b0, "R12 region0 after reset");
  endtask

  task automatic t_default_deny;
    acc(40'h1000, 2'd0, 4'd3, 1'b0, "R6 no region matches -> deny");
    chk("R9 first denial recorded", fail_status, st(40'h1000, 1'b0, 4'd3));
  endtask

  task automatic t_layout;
    wr_cfg(4'd5, 64'h67FF_FFFF_FFFF_FFFF, 1'b0, "R1 write err low");
    rd_cfg(4'd5, 64'h0700_003F_FFFF_FFFF, 1'b0, "R1 reserved bits read zero");
  endtask

  task automatic t_napot;
    wr_cfg(4'd0, mk(fld(40'h1000, 40'h100), 3'b001, 2'd3, 1'b0), 1'b0, "R4 program r0");
    acc(40'h1080, 2'd0, 4'd1, 1'b1, "R4 read inside window");
    acc(40'h10FC, 2'd0, 4'd1, 1'b1, "R4 last word of window");
    acc(40'h1100, 2'd0, 4'd1, 1'b0, "R4 first byte past window");
    acc(40'h0FFC, 2'd0, 4'd1, 1'b0, "R4 word below window");
    acc(40'h1080, 2'd1, 4'd1, 1'b0, "R7 write without write bit");
    acc(40'h1000, 2'd2, 4'd1, 1'b0, "R7 exec without exec bit");
  endtask

  task automatic t_priority;
    wr_cfg(4'd1, mk(fld(40'h1000, 40'h1000), 3'b111, 2'd3, 1'b0), 1'b0, "R6 program r1");
    acc(40'h1010, 2'd1, 4'd2, 1'b0, "R6 lower region r0 decides");
    acc(40'h1800, 2'd1, 4'd2, 1'b1, "R6 only r1 matches, write ok");
    acc(40'h1FFC, 2'd2, 4'd2, 1'b1, "R7 exec granted by r1");
    acc(40'h1800, 2'd3, 4'd2, 1'b0, "R7 reserved type denied");
  endtask

  task automatic t_small;
    wr_cfg(4'd2, mk(fld(40'h4000, 40'h8), 3'b100, 2'd3, 1'b0), 1'b0, "R4 program 8-byte r2");
    acc(40'h4000, 2'd2, 4'd0, 1'b1, "R4 8-byte region low word");
    acc(40'h4004, 2'd2, 4'd0, 1'b1, "R4 8-byte region high word");
    acc(40'h4008, 2'd2, 4'd0, 1'b0, "R4 past 8-byte region");
    acc(40'h4004, 2'd0, 4'd0, 1'b0, "R7 read in exec-only region");
  endtask

  task automatic t_off;
    wr_cfg(4'd3, mk(fld(40'h8000, 40'h100), 3'b111, 2'd0, 1'b0), 1'b0, "R5 program r3 off");
    acc(40'h8010, 2'd0, 4'd0, 1'b0, "R5 mode 0 never matches");
    wr_cfg(4'd3, mk(fld(40'h8000, 40'h100), 3'b111, 2'd1, 1'b0), 1'b0, "R5 program r3 mode1");
    acc(40'h8010, 2'd0, 4'd0, 1'b0, "R5 mode 1 never matches");
    wr_cfg(4'd6, mk(fld(40'h9000, 40'h100), 3'b000, 2'd3, 1'b0), 1'b0, "R7 program r6 no perms");
    acc(40'h9040, 2'd0, 4'd0, 1'b0, "R7 region without perms denies");
  endtask

  task automatic t_range;
    wr_cfg(4'd8, mk(fld(40'h1000, 40'h100), 3'b111, 2'd3, 1'b0), 1'b1, "R2 write idx 8 error");
    rd_cfg(4'd12, 64'd0, 1'b1, "R2 read idx 12 error, zero data");
    rd_cfg(4'd7, 64'd0, 1'b0, "R2 idx 7 in range");
    acc(40'h1080, 2'd1, 4'd0, 1'b0, "R2 rejected write had no effect");
  endtask

  task automatic t_lock;
    logic [63:0] locked;
    locked = mk(fld(40'hA000, 40'h100), 3'b001, 2'd3, 1'b1);
    wr_cfg(4'd4, locked, 1'b0, "R3 program locked r4");
    wr_cfg(4'd4, mk(fld(40'hA000, 40'h100), 3'b011, 2'd3, 1'b0), 1'b0, "R3 overwrite attempt");
    rd_cfg(4'd4, locked, 1'b0, "R3 locked word unchanged");
    acc(40'hA010, 2'd0, 4'd0, 1'b1, "R3 read still allowed");
    acc(40'hA010, 2'd1, 4'd0, 1'b0, "R3 write still denied");
  endtask

  task automatic t_fail;
    chk("R10 record kept through later denials", fail_status, st(40'h1000, 1'b0, 4'd3));
    fail_clear = 1'b1;
    @(negedge clk);
    fail_clear = 1'b0;
    chk("R11 clear empties record", fail_status, 64'd0);
    fail_clear = 1'b1;
    acc(40'h4008, 2'd2, 4'd6, 1'b0, "R11 denial during clear");
    fail_clear = 1'b0;
    chk("R11 clear wins over denial", fail_status, 64'd0);
    acc(40'hA010, 2'd1, 4'd5, 1'b0, "R9 write denial");
    chk("R9 write denial recorded", fail_status, st(40'hA010, 1'b1, 4'd5));
    acc(40'h4008, 2'd2, 4'd9, 1'b0, "R10 second denial");
    chk("R10 second denial not recorded", fail_status, st(40'hA010, 1'b1, 4'd5));
  endtask

  task automatic t_full;
    wr_cfg(4'd7, mk({38{1'b1}}, 3'b111, 2'd3, 1'b0), 1'b0, "R4 program all-ones r7");
    acc(40'h20_0000_0000, 2'd1, 4'd0, 1'b1, "R4 all-ones field covers high address");
    acc(40'h1010, 2'd1, 4'd0, 1'b0, "R6 r0 still beats r7");
    @(negedge clk);
    chk("R8 no response without request", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_default_deny();
    t_layout();
    t_napot();
    t_priority();
    t_small();
    t_off();
    t_range();
    t_lock();
    t_fail();
    t_full();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R8 watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end
endmodule